// File: doc/BRIEF.md
# Receive Status Trailer Appender

This block sits on the receive byte stream behind the MAC receive logic. While a frame is in flight it forwards each data byte unchanged. It also counts the bytes and collects the error indications that the MAC raises during the frame. Once the frame's end beat has been accepted, the block appends four status bytes to the same stream.

Two of the four bytes form a little-endian 16-bit status word. That word holds a saturating byte count in its low twelve bits and four error flags in its top nibble. The other two bytes report two event counters: a runt-frame counter and a receive-collision counter. Each counter is advanced by its own strobe. Both directions use valid/ready handshakes. Input is held off while the trailer drains, so the trailer can never interleave with the next frame.

Top module: `rxt_status_trailer`

## Requirements
- R1: While no trailer is pending, `out_valid`, `out_data` and `in_ready` follow `in_valid`, `in_data` and `out_ready` in the same cycle.
- R2: Exactly four trailer bytes follow each accepted end-of-frame beat. The first trailer byte is offered in the cycle after that beat. `out_last` is high only on the fourth trailer byte.
- R3: Trailer byte 0 is bits 7:0 of the status word and byte 1 is bits 15:8. Word bits 11:0 hold the byte count. Bit 15 is FIFO overflow (`err_fifo_ovf`), bit 14 is late collision (`err_late_coll`), bit 13 is framing error (`err_framing`) and bit 12 is FCS error (`err_fcs`).
- R4: The byte count includes the start and end beats. It saturates at 4095 and does not wrap.
- R5: An error input that is high on any accepted beat of a frame sets its flag until that frame's trailer. An accepted start beat clears all flags, except those whose inputs are high on that same start beat.
- R6: Trailer byte 2 is the runt counter and byte 3 is the collision counter. Each is an 8-bit count of strobe cycles since reset, wrapping modulo 256. Both are captured as they stand when the end beat is accepted, before any strobe in that same cycle is counted.
- R7: `in_ready` is low from the cycle after the end beat is accepted until the fourth trailer byte has been accepted.
- R8: While a trailer byte is offered and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R9: During reset and after it, the block is in the data phase with counts and counters at zero. `out_valid` is therefore low when `in_valid` is low.
- R10: A frame whose single beat carries both start and end reports a byte count of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Receive byte valid |
| in_ready | output | 1 | Receive byte accepted when high with in_valid |
| in_data | input | 8 | Receive byte |
| in_sof | input | 1 | First byte of frame |
| in_eof | input | 1 | Last byte of frame |
| err_fifo_ovf | input | 1 | FIFO overflow seen on this beat |
| err_late_coll | input | 1 | Late collision seen on this beat |
| err_framing | input | 1 | Framing error seen on this beat |
| err_fcs | input | 1 | FCS error seen on this beat |
| runt_inc | input | 1 | Runt counter increment strobe |
| coll_inc | input | 1 | Collision counter increment strobe |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts output byte |
| out_data | output | 8 | Output byte (data or trailer) |
| out_last | output | 1 | Final trailer byte of a frame |

## Verification
The assertions check the following on every cycle:
- the input stall during the trailer;
- the position of `out_last`;
- entry to the trailer one cycle after the end beat;
- trailer data holding steady under backpressure;
- the count staying pinned once saturated;
- transparency in the data phase.

Only the bench scenarios can show that the packed trailer values are right. This covers:
- the little-endian order;
- where each flag lands in the word;
- that flags stick through a frame and clear at the next start;
- the captured counter values, including wrap.

// File: rtl/rxt_pkg.sv
package rxt_pkg;
    typedef enum logic {PH_DATA = 1'b0, PH_TRAILER = 1'b1} phase_e;
    localparam int TRL_BYTES = 4;
    localparam int BYTE_W    = 8;
    localparam int WORD_W    = 16;
    localparam int NFLAG     = 4;
endpackage

// File: rtl/rxt_frame_acc.sv
module rxt_frame_acc #(
    parameter int CNT_W = 12,
    parameter int NFLAG = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat,
    input  logic             sof,
    input  logic [NFLAG-1:0] flags_in,
    output logic [CNT_W-1:0] cnt_nx,
    output logic [NFLAG-1:0] flg_nx,
    output logic [CNT_W-1:0] cnt_cur
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [NFLAG-1:0] flg;
    } acc_t;

    acc_t acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (beat) begin
            if (sof) begin
                acc_d.cnt = CNT_W'(1);
                acc_d.flg = flags_in;
            end else begin
                acc_d.cnt = (acc_q.cnt == CNT_MAX) ? CNT_MAX : acc_q.cnt + CNT_W'(1);
                acc_d.flg = acc_q.flg | flags_in;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign cnt_nx  = acc_d.cnt;
    assign flg_nx  = acc_d.flg;
    assign cnt_cur = acc_q.cnt;
endmodule

// File: rtl/rxt_evt_cnt.sv
module rxt_evt_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] value
);
    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (inc) val_d = val_q + W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign value = val_q;
endmodule

// File: rtl/rxt_status_trailer.sv
module rxt_status_trailer #(
    parameter int CNT_W = 12,
    parameter int EVT_W = 8,
    parameter int N_EVT = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_sof,
    input  logic       in_eof,
    input  logic       err_fifo_ovf,
    input  logic       err_late_coll,
    input  logic       err_framing,
    input  logic       err_fcs,
    input  logic       runt_inc,
    input  logic       coll_inc,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_data,
    output logic       out_last
);
    import rxt_pkg::*;

    localparam int IDX_W = $clog2(TRL_BYTES);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(TRL_BYTES - 1);

    typedef struct packed {
        phase_e                                phase;
        logic [IDX_W-1:0]                      idx;
        logic [TRL_BYTES-1:0][BYTE_W-1:0]      trl;
    } seq_t;

    seq_t seq_d, seq_q;

    logic             beat;
    logic [NFLAG-1:0] flags_in;
    logic [CNT_W-1:0] cnt_nx;
    logic [NFLAG-1:0] flg_nx;
    logic [CNT_W-1:0] cnt_cur;
    logic [N_EVT-1:0] evt_inc;
    logic [N_EVT-1:0][EVT_W-1:0] evt_val;
    logic [WORD_W-1:0] status_word;
    logic             trl_active;
    logic [IDX_W-1:0] trl_idx;

    assign flags_in = {err_fifo_ovf, err_late_coll, err_framing, err_fcs};
    assign evt_inc  = {coll_inc, runt_inc};

    rxt_frame_acc #(.CNT_W(CNT_W), .NFLAG(NFLAG)) acc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .beat     (beat),
        .sof      (in_sof),
        .flags_in (flags_in),
        .cnt_nx   (cnt_nx),
        .flg_nx   (flg_nx),
        .cnt_cur  (cnt_cur)
    );

    for (genvar g = 0; g < N_EVT; g++) begin : g_evt
        rxt_evt_cnt #(.W(EVT_W)) cnt_i (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (evt_inc[g]),
            .value (evt_val[g])
        );
    end

    always_comb begin
        status_word = '0;
        status_word[CNT_W-1:0] = cnt_nx;
        status_word[WORD_W-1 -: NFLAG] = flg_nx;
    end

    always_comb begin
        seq_d     = seq_q;
        in_ready  = (seq_q.phase == PH_DATA) && out_ready;
        beat      = in_valid && in_ready;
        out_valid = (seq_q.phase == PH_DATA) ? in_valid : 1'b1;
        out_data  = (seq_q.phase == PH_DATA) ? in_data : seq_q.trl[seq_q.idx];
        out_last  = (seq_q.phase == PH_TRAILER) && (seq_q.idx == IDX_LAST);

        if (seq_q.phase == PH_DATA) begin
            if (beat && in_eof) begin
                seq_d.phase  = PH_TRAILER;
                seq_d.idx    = '0;
                seq_d.trl[0] = status_word[BYTE_W-1:0];
                seq_d.trl[1] = status_word[WORD_W-1:BYTE_W];
                for (int k = 0; k < N_EVT; k++) begin
                    seq_d.trl[2+k] = '0;
                    seq_d.trl[2+k][EVT_W-1:0] = evt_val[k];
                end
            end
        end else if (out_ready) begin
            if (seq_q.idx == IDX_LAST) begin
                seq_d.phase = PH_DATA;
                seq_d.idx   = '0;
            end else begin
                seq_d.idx = seq_q.idx + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '{phase: PH_DATA, idx: '0, trl: '0};
        else        seq_q <= seq_d;
    end

    assign trl_active = (seq_q.phase == PH_TRAILER);
    assign trl_idx    = seq_q.idx;
endmodule

// File: rtl/rxt_status_trailer_chk.sv
module rxt_status_trailer_chk #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [7:0]       in_data,
    input logic             in_sof,
    input logic             in_eof,
    input logic             out_valid,
    input logic             out_ready,
    input logic [7:0]       out_data,
    input logic             out_last,
    input logic             trl_active,
    input logic [1:0]       trl_idx,
    input logic [CNT_W-1:0] cnt_cur
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    assert_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !trl_active |-> (out_valid == in_valid && out_data == in_data && in_ready == out_ready));

    assert_last_pos_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |-> (trl_active && trl_idx == 2'd3));

    assert_eof_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_eof) |=> (trl_active && trl_idx == 2'd0));

    assert_sat_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_cur == CNT_MAX && !(in_valid && in_ready && in_sof)) |=> (cnt_cur == CNT_MAX));

    assert_trl_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trl_active |-> !in_ready);

    assert_bp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trl_active && !out_ready) |=> (trl_active && out_valid && $stable(out_data) && $stable(trl_idx)));
endmodule

bind rxt_status_trailer rxt_status_trailer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .in_sof     (in_sof),
    .in_eof     (in_eof),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_last   (out_last),
    .trl_active (trl_active),
    .trl_idx    (trl_idx),
    .cnt_cur    (cnt_cur)
);

// File: tb/rxt_status_trailer_tb.sv
module rxt_status_trailer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0] in_data = '0;
    logic [3:0] err = '0;
    logic       runt_inc = 1'b0, coll_inc = 1'b0;
    logic       out_ready = 1'b1;
    logic       in_ready, out_valid, out_last;
    logic [7:0] out_data;

    int n_chk = 0;
    int n_err = 0;
    int ready_mode = 0;
    int tick = 0;
    int exp_runt = 0;
    int exp_coll = 0;
    logic [7:0] q_data[$];
    logic       q_last[$];

    always #4 clk = ~clk;

    rxt_status_trailer dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof),
        .err_fifo_ovf(err[3]), .err_late_coll(err[2]),
        .err_framing(err[1]), .err_fcs(err[0]),
        .runt_inc(runt_inc), .coll_inc(coll_inc),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last)
    );

    always @(posedge clk) begin
        #2;
        tick++;
        case (ready_mode)
            0: out_ready = 1'b1;
            1: out_ready = (tick % 3) != 0;
            default: out_ready = 1'b0;
        endcase
    end

    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            q_data.push_back(out_data);
            q_last.push_back(out_last);
        end
    end

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_frame(int n, int errbeat, logic [3:0] mask);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1;
            in_data  = 8'((i * 7 + n) & 255);
            in_sof   = (i == 0);
            in_eof   = (i == n - 1);
            err      = (i == errbeat) ? mask : 4'b0;
            do @(negedge clk); while (!in_ready);
            @(posedge clk); #1;
        end
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; err = '0;
    endtask

    task automatic wait_out(int total);
        int guard = 0;
        while (q_data.size() < total && guard < 20000) begin
            @(posedge clk); #1;
            guard++;
        end
    endtask

    task automatic check_frame(string req, int n, logic [3:0] flags);
        int cnt = (n > 4095) ? 4095 : n;
        int bad = 0;
        logic [15:0] w;
        wait_out(n + 4);
        check({req, " length"}, q_data.size(), n + 4);
        if (q_data.size() == n + 4) begin
            for (int i = 0; i < n; i++) begin
                if (q_data[i] !== 8'((i * 7 + n) & 255) || q_last[i] !== 1'b0) bad++;
            end
            check("R1 data bytes", bad, 0);
            w = {flags, 12'(cnt)};
            check({req, " byte0"}, q_data[n], w[7:0]);
            check({req, " byte1"}, q_data[n+1], w[15:8]);
            check("R6 runt byte", q_data[n+2], exp_runt % 256);
            check("R6 coll byte", q_data[n+3], exp_coll % 256);
            check("R2 last flags", {q_last[n], q_last[n+1], q_last[n+2], q_last[n+3]}, 1);
        end
        q_data.delete();
        q_last.delete();
    endtask

    task automatic t_reset();
        check("R9 out_valid", out_valid, 0);
        check("R9 in_ready", in_ready, 1);
    endtask

    task automatic t_plain();
        send_frame(10, -1, 4'b0);
        check_frame("R3 plain", 10, 4'b0);
    endtask

    task automatic t_flags();
        send_frame(6, 0, 4'b1000);
        check_frame("R3 ovf bit15", 6, 4'b1000);
        send_frame(6, 5, 4'b0001);
        check_frame("R3 fcs bit12", 6, 4'b0001);
        send_frame(9, 3, 4'b0110);
        check_frame("R5 sticky", 9, 4'b0110);
        send_frame(9, -1, 4'b0);
        check_frame("R5 cleared", 9, 4'b0);
    endtask

    task automatic t_counters();
        runt_inc = 1'b1;
        repeat (260) begin @(posedge clk); #1; end
        runt_inc = 1'b0;
        exp_runt += 260;
        coll_inc = 1'b1;
        repeat (3) begin @(posedge clk); #1; end
        coll_inc = 1'b0;
        exp_coll += 3;
        send_frame(5, -1, 4'b0);
        check_frame("R6 counters", 5, 4'b0);
    endtask

    task automatic t_saturate();
        send_frame(4100, -1, 4'b0);
        check_frame("R4 saturate", 4100, 4'b0);
        send_frame(4095, -1, 4'b0);
        check_frame("R4 at max", 4095, 4'b0);
    endtask

    task automatic t_backpressure();
        ready_mode = 1;
        send_frame(20, 10, 4'b0100);
        check_frame("R8 toggled ready", 20, 4'b0100);
        ready_mode = 0;
        @(posedge clk); #1;
    endtask

    task automatic t_stall();
        in_valid = 1'b1; in_data = 8'h5A; in_sof = 1'b1; in_eof = 1'b1;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        ready_mode = 2;
        in_data = 8'hC3; in_eof = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check("R7 in_ready low", in_ready, 0);
            check("R8 out_valid held", out_valid, 1);
            check("R8 byte0 held", out_data, 1);
        end
        in_valid = 1'b0; in_sof = 1'b0;
        ready_mode = 0;
        wait_out(5);
        check("R10 data byte", q_data[0], 8'h5A);
        check("R10 count", q_data[1], 1);
        check("R10 hi", q_data[2], 0);
        q_data.delete();
        q_last.delete();
    endtask

    initial begin
        #1_200_000;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        @(negedge clk);
        t_reset();
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;
        t_plain();
        t_flags();
        t_counters();
        t_stall();
        t_backpressure();
        t_saturate();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end
endmodule